// File: doc/BRIEF.md
# TLB Refill Slot Selector

This block chooses the slot that a translation refill lands in and produces the write for that slot. The translation buffer behind it has two regions. The first is a set-associative array of 8 ways by 256 lines, and every entry in it uses one shared page size. The second is a 16-entry fully associative region, and each entry there keeps its own page size. A refill whose requested page size equals the shared size goes to a pseudo-randomly chosen way. The line within that way comes from the virtual address. A refill of any other size goes to a pseudo-random slot of the associative region.

The caller holds two copies of the entry-high and entry-low words and of the page size: the normal copy and the copy used during a refill exception. A mode flag selects between them. The block keeps a small shadow of the exists bit, global bit and address-space tag of every slot. With it the block can report, on the same cycle as the write, whether the old occupant of the slot must be flushed from any downstream translation cache.

Top module: `tlbfill_sel`

## Requirements
- R1: A page size is legal only when its bit is set in `ps_support` (bit n stands for size n). If the requested size or the shared size is illegal, the request produces no write and no invalidate strobe, and the shadow state is unchanged.
- R2: When `refill_mode` is 1, the VPPN, the two low words and the requested size come from the `rf_*` inputs. When it is 0, they come from `ehi_vppn`, `elo0`, `elo1` and `idx_ps`.
- R3: When the requested size equals `shared_ps`, the written index is below 2048, and `wr_index % 256` equals `(({vppn,13'b0}) >> (shared_ps+1)) & 8'hFF`.
- R4: A set-associative index is way*256 + line. Over a run of fills to one line, more than one way is chosen.
- R5: When the requested size differs from `shared_ps`, the index lies in 2048..2063, `wr_ps_en` is 1 and `wr_ps` equals the requested size. For set-associative writes `wr_ps_en` and `wr_ps` are 0.
- R6: A legal request (`fill_req` high at a rising edge) gives `wr_en`=1 on the next cycle, together with the selected VPPN, both low words and `wr_asid` equal to `cur_asid`.
- R7: `old_inval` is 1 with the write exactly when the slot already held an entry and that entry was either global (bit 6 of its low word 0) or tagged with the current `cur_asid`.
- R8: With `fill_req` low, `wr_en` and `old_inval` are 0 on the next cycle.
- R9: After reset, no slot holds an entry and all outputs are 0.
- R10: Over a run of fills, more than one associative slot is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req | input | 1 | Refill request, one cycle |
| refill_mode | input | 1 | Take the refill-exception copies |
| ehi_vppn | input | 35 | Normal entry-high VPPN (VA[47:13]) |
| idx_ps | input | 6 | Normal requested page size |
| elo0 | input | 64 | Normal entry-low word, even page |
| elo1 | input | 64 | Normal entry-low word, odd page |
| rf_vppn | input | 35 | Refill entry-high VPPN |
| rf_ps | input | 6 | Refill requested page size |
| rf_lo0 | input | 64 | Refill entry-low word, even page |
| rf_lo1 | input | 64 | Refill entry-low word, odd page |
| shared_ps | input | 6 | Page size of the set-associative region |
| ps_support | input | 64 | Supported page size mask |
| cur_asid | input | 10 | Current address-space tag |
| wr_en | output | 1 | Slot write strobe |
| wr_index | output | 12 | Slot written |
| wr_vppn | output | 35 | VPPN written |
| wr_lo0 | output | 64 | Even low word written |
| wr_lo1 | output | 64 | Odd low word written |
| wr_asid | output | 10 | Tag written |
| wr_ps | output | 6 | Per-entry page size (associative slots only) |
| wr_ps_en | output | 1 | Per-entry page size is valid |
| old_inval | output | 1 | Old occupant must be flushed |

## Verification
Two things can happen in the same cycle: a write into a slot and the check of that slot's previous occupant. When fills come back to back, the occupant check must already see the write made one cycle earlier. The bench issues long runs of consecutive fills that all target one line, and it changes the current tag and the global bit between them, so the eight ways fill up and are hit again. A behavioural model of the shadow state is updated from the index that was actually written. On every cycle the model judges whether `old_inval` should have fired. The model also checks that the index satisfies the region and line rules.

// File: rtl/tlbfill_pkg.sv
package tlbfill_pkg;
   localparam int unsigned ASID_W     = 10;
   localparam int unsigned PS_W       = 6;
   localparam int unsigned VPPN_W     = 35;
   localparam int unsigned VPPN_SHIFT = 13;
   localparam int unsigned LO_W       = 64;
   localparam int unsigned GLOBAL_BIT = 6;

   typedef struct packed {
      logic              present;
      logic              glob;
      logic [ASID_W-1:0] asid;
   } slot_tag_t;

   function automatic logic evict_needed(slot_tag_t t, logic [ASID_W-1:0] asid);
      return t.present && (t.glob || (t.asid == asid));
   endfunction
endpackage

// File: rtl/tlbfill_lfsr.sv
module tlbfill_lfsr #(
   parameter int unsigned W    = 16,
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] rnd
);
   if (W != 16) begin : g_bad_w
      $error("tlbfill_lfsr supports W=16 only");
   end
   if (SEED == 16'h0) begin : g_bad_seed
      $error("tlbfill_lfsr seed must be nonzero");
   end

   logic [15:0] state;
   logic        fb;

   always_comb fb = state[15] ^ state[13] ^ state[12] ^ state[10];

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SEED;
      else        state <= {state[14:0], fb};
   end

   assign rnd = state;
endmodule

// File: rtl/tlbfill_index.sv
module tlbfill_index
   import tlbfill_pkg::*;
#(
   parameter int unsigned SA_WAYS    = 8,
   parameter int unsigned SA_LINES   = 256,
   parameter int unsigned FA_ENTRIES = 16,
   parameter int unsigned RND_W      = 16,
   parameter int unsigned IDX_W      = 12
) (
   input  logic              to_sa,
   input  logic [VPPN_W-1:0] vppn,
   input  logic [PS_W-1:0]   sa_ps,
   input  logic [RND_W-1:0]  rnd,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned SA_TOTAL = SA_WAYS * SA_LINES;
   localparam int unsigned LINE_W   = (SA_LINES > 1) ? $clog2(SA_LINES) : 1;
   localparam int unsigned WAY_W    = (SA_WAYS  > 1) ? $clog2(SA_WAYS)  : 1;
   localparam int unsigned FA_W     = (FA_ENTRIES > 1) ? $clog2(FA_ENTRIES) : 1;
   localparam int unsigned VA_W     = VPPN_W + VPPN_SHIFT;

   if ((1 << LINE_W) != SA_LINES) begin : g_bad_lines
      $error("tlbfill_index: SA_LINES must be a power of two");
   end

   logic [VA_W-1:0]   va;
   logic [VA_W-1:0]   va_sh;
   logic [LINE_W-1:0] line;
   logic [WAY_W-1:0]  way;
   logic [FA_W-1:0]   fa_slot;
   logic [IDX_W-1:0]  sa_idx;
   logic [IDX_W-1:0]  fa_idx;

   always_comb begin
      va    = {vppn, {VPPN_SHIFT{1'b0}}};
      va_sh = va >> ({1'b0, sa_ps} + 7'd1);
      line  = va_sh[LINE_W-1:0];
   end

   // way reduction: bit slice for powers of two, modulo otherwise
   if ((1 << WAY_W) == SA_WAYS) begin : g_way_pow2
      assign way = rnd[WAY_W-1:0];
   end else begin : g_way_mod
      assign way = WAY_W'(rnd % RND_W'(SA_WAYS));
   end

   if ((1 << FA_W) == FA_ENTRIES) begin : g_fa_pow2
      assign fa_slot = rnd[RND_W-1 -: FA_W];
   end else begin : g_fa_mod
      assign fa_slot = FA_W'(rnd % RND_W'(FA_ENTRIES));
   end

   always_comb begin
      sa_idx = IDX_W'(way) * IDX_W'(SA_LINES) + IDX_W'(line);
      fa_idx = IDX_W'(SA_TOTAL) + IDX_W'(fa_slot);
      idx    = to_sa ? sa_idx : fa_idx;
   end
endmodule

// File: rtl/tlbfill_tagstore.sv
module tlbfill_tagstore
   import tlbfill_pkg::*;
#(
   parameter int unsigned DEPTH = 2064,
   parameter int unsigned IDX_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   output slot_tag_t         rd_tag,
   input  logic              we,
   input  slot_tag_t         wr_tag
);
   if ((1 << IDX_W) < DEPTH) begin : g_bad_depth
      $error("tlbfill_tagstore: IDX_W too small for DEPTH");
   end

   slot_tag_t tags [DEPTH];

   always_comb begin
      if (32'(idx) < DEPTH) rd_tag = tags[idx];
      else                  rd_tag = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) tags[i] <= '0;
      end else if (we && (32'(idx) < DEPTH)) begin
         tags[idx] <= wr_tag;
      end
   end
endmodule

// File: rtl/tlbfill_sel.sv
module tlbfill_sel
   import tlbfill_pkg::*;
#(
   parameter int unsigned SA_WAYS    = 8,
   parameter int unsigned SA_LINES   = 256,
   parameter int unsigned FA_ENTRIES = 16,
   parameter int unsigned IDX_W      = 12,
   parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_req,
   input  logic              refill_mode,
   input  logic [34:0]       ehi_vppn,
   input  logic [5:0]        idx_ps,
   input  logic [63:0]       elo0,
   input  logic [63:0]       elo1,
   input  logic [34:0]       rf_vppn,
   input  logic [5:0]        rf_ps,
   input  logic [63:0]       rf_lo0,
   input  logic [63:0]       rf_lo1,
   input  logic [5:0]        shared_ps,
   input  logic [63:0]       ps_support,
   input  logic [9:0]        cur_asid,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_index,
   output logic [34:0]       wr_vppn,
   output logic [63:0]       wr_lo0,
   output logic [63:0]       wr_lo1,
   output logic [9:0]        wr_asid,
   output logic [5:0]        wr_ps,
   output logic              wr_ps_en,
   output logic              old_inval
);
   localparam int unsigned TOTAL = SA_WAYS * SA_LINES + FA_ENTRIES;
   localparam int unsigned RND_W = 16;

   if (SA_WAYS < 1 || FA_ENTRIES < 1) begin : g_bad_cnt
      $error("tlbfill_sel: region sizes must be nonzero");
   end
   if ((1 << IDX_W) < TOTAL) begin : g_bad_idx
      $error("tlbfill_sel: IDX_W too small");
   end

   logic [RND_W-1:0]  rnd;
   logic [VPPN_W-1:0] src_vppn;
   logic [PS_W-1:0]   src_ps;
   logic [LO_W-1:0]   src_lo0;
   logic [LO_W-1:0]   src_lo1;
   logic              ps_ok;
   logic              go;
   logic              to_sa;
   logic [IDX_W-1:0]  sel_idx;
   slot_tag_t         old_tag;
   slot_tag_t         new_tag;

   tlbfill_lfsr #(.W(RND_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .rnd(rnd)
   );

   always_comb begin
      if (refill_mode) begin
         src_vppn = rf_vppn;
         src_ps   = rf_ps;
         src_lo0  = rf_lo0;
         src_lo1  = rf_lo1;
      end else begin
         src_vppn = ehi_vppn;
         src_ps   = idx_ps;
         src_lo0  = elo0;
         src_lo1  = elo1;
      end
      ps_ok = ps_support[src_ps] && ps_support[shared_ps];
      go    = fill_req && ps_ok;
      to_sa = (src_ps == shared_ps);
   end

   tlbfill_index #(
      .SA_WAYS(SA_WAYS), .SA_LINES(SA_LINES), .FA_ENTRIES(FA_ENTRIES),
      .RND_W(RND_W), .IDX_W(IDX_W)
   ) u_index (
      .to_sa(to_sa), .vppn(src_vppn), .sa_ps(shared_ps), .rnd(rnd), .idx(sel_idx)
   );

   always_comb begin
      new_tag.present = 1'b1;
      new_tag.glob    = src_lo0[GLOBAL_BIT];
      new_tag.asid    = cur_asid;
   end

   tlbfill_tagstore #(.DEPTH(TOTAL), .IDX_W(IDX_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(sel_idx), .rd_tag(old_tag),
      .we(go), .wr_tag(new_tag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en     <= 1'b0;
         wr_index  <= '0;
         wr_vppn   <= '0;
         wr_lo0    <= '0;
         wr_lo1    <= '0;
         wr_asid   <= '0;
         wr_ps     <= '0;
         wr_ps_en  <= 1'b0;
         old_inval <= 1'b0;
      end else begin
         wr_en     <= go;
         old_inval <= go && evict_needed(old_tag, cur_asid);
         wr_ps_en  <= go && !to_sa;
         if (go) begin
            wr_index <= sel_idx;
            wr_vppn  <= src_vppn;
            wr_lo0   <= src_lo0;
            wr_lo1   <= src_lo1;
            wr_asid  <= cur_asid;
            wr_ps    <= to_sa ? '0 : src_ps;
         end
      end
   end
endmodule

// File: rtl/tlbfill_sel_chk.sv
module tlbfill_sel_chk #(
   parameter int unsigned SA_TOTAL = 2048,
   parameter int unsigned TOTAL    = 2064,
   parameter int unsigned IDX_W    = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fill_req,
   input logic [5:0]       shared_ps,
   input logic [63:0]      ps_support,
   input logic [9:0]       cur_asid,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_index,
   input logic [9:0]       wr_asid,
   input logic [5:0]       wr_ps,
   input logic             wr_ps_en,
   input logic             old_inval
);
   assert_illegal_shared_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !ps_support[shared_ps]) |=> !wr_en);
   assert_sa_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ps_en) |-> (32'(wr_index) < SA_TOTAL && wr_ps == 6'd0));
   assert_fa_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ps_en |-> (wr_en && 32'(wr_index) >= SA_TOTAL && 32'(wr_index) < TOTAL));
   assert_asid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_asid == $past(cur_asid)));
   assert_inval_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      old_inval |-> wr_en);
   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_req |=> (!wr_en && !old_inval));
endmodule

bind tlbfill_sel tlbfill_sel_chk #(
   .SA_TOTAL(SA_WAYS * SA_LINES), .TOTAL(SA_WAYS * SA_LINES + FA_ENTRIES), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .shared_ps(shared_ps),
   .ps_support(ps_support), .cur_asid(cur_asid), .wr_en(wr_en), .wr_index(wr_index),
   .wr_asid(wr_asid), .wr_ps(wr_ps), .wr_ps_en(wr_ps_en), .old_inval(old_inval)
);

// File: tb/tlbfill_sel_test.sv
module tlbfill_sel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_req = 1'b0, refill_mode = 1'b0;
   logic [34:0] ehi_vppn = '0, rf_vppn = '0;
   logic [5:0]  idx_ps = '0, rf_ps = '0, shared_ps = 6'd12;
   logic [63:0] elo0 = '0, elo1 = '0, rf_lo0 = '0, rf_lo1 = '0;
   logic [63:0] ps_support = '0;
   logic [9:0]  cur_asid = '0;
   logic        wr_en, wr_ps_en, old_inval;
   logic [11:0] wr_index;
   logic [34:0] wr_vppn;
   logic [63:0] wr_lo0, wr_lo1;
   logic [9:0]  wr_asid;
   logic [5:0]  wr_ps;

   always #5 clk = ~clk;

   tlbfill_sel uut (.*);

   int tests = 0, fails = 0;
   bit finished = 0;
   bit tag_e [0:2063];
   bit tag_g [0:2063];
   int tag_a [0:2063];
   bit way_seen [0:7];
   bit fa_seen [0:15];

   // expectation captured when a request is presented
   bit      x_wr, x_sa, x_req, x_mode;
   longint  x_vppn, x_lo0, x_lo1;
   int      x_asid, x_ps, x_line;

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic capture();
      bit legal;
      longint va;
      x_mode = refill_mode;
      x_vppn = refill_mode ? longint'(rf_vppn) : longint'(ehi_vppn);
      x_lo0  = refill_mode ? rf_lo0 : elo0;
      x_lo1  = refill_mode ? rf_lo1 : elo1;
      x_ps   = refill_mode ? int'(rf_ps) : int'(idx_ps);
      x_asid = int'(cur_asid);
      legal  = ps_support[x_ps] && ps_support[shared_ps];
      x_req  = fill_req;
      x_wr   = fill_req && legal;
      x_sa   = (x_ps == int'(shared_ps));
      va     = x_vppn << 13;
      x_line = int'((va >> (int'(shared_ps) + 1)) & 255);
   endtask

   task automatic compare();
      int  idx;
      bit  e_inv;
      string rq;
      rq = !x_req ? "R8" : (x_wr ? "R6" : "R1");
      chk(wr_en == x_wr, rq, "wr_en", wr_en, x_wr);
      if (!x_wr) begin
         chk(old_inval == 1'b0, rq, "old_inval idle", old_inval, 0);
         return;
      end
      if (!wr_en) return;
      idx = int'(wr_index);
      chk(wr_vppn == x_vppn, x_mode ? "R2" : "R6", "vppn", wr_vppn, x_vppn);
      chk(wr_lo0 == x_lo0, x_mode ? "R2" : "R6", "lo0", wr_lo0, x_lo0);
      chk(wr_lo1 == x_lo1, "R6", "lo1", wr_lo1, x_lo1);
      chk(int'(wr_asid) == x_asid, "R6", "asid", wr_asid, x_asid);
      if (x_sa) begin
         chk(idx < 2048, "R3", "sa index range", idx, 2047);
         chk(idx % 256 == x_line, "R3", "line", idx % 256, x_line);
         chk(wr_ps_en == 0 && wr_ps == 0, "R5", "sa ps fields", wr_ps_en, 0);
         if (idx < 2048) way_seen[idx / 256] = 1;
      end else begin
         chk(idx >= 2048 && idx < 2064, "R5", "fa index range", idx, 2048);
         chk(wr_ps_en == 1 && int'(wr_ps) == x_ps, "R5", "fa ps", wr_ps, x_ps);
         if (idx >= 2048 && idx < 2064) fa_seen[idx - 2048] = 1;
      end
      if (idx < 2064) begin
         e_inv = tag_e[idx] && (tag_g[idx] || tag_a[idx] == x_asid);
         chk(old_inval == e_inv, "R7", "old_inval", old_inval, e_inv);
         tag_e[idx] = 1;
         tag_g[idx] = x_lo0[6];
         tag_a[idx] = x_asid;
      end
   endtask

   task automatic cycle();
      capture();
      @(posedge clk);
      @(negedge clk);
      compare();
      fill_req = 0;
   endtask

   task automatic fill(bit mode, longint vppn, int ps, longint lo0, int asid);
      refill_mode = mode;
      cur_asid = 10'(asid);
      if (mode) begin
         rf_vppn = 35'(vppn); rf_ps = 6'(ps); rf_lo0 = lo0; rf_lo1 = ~lo0;
         ehi_vppn = 35'(vppn ^ 35'h5A5); idx_ps = 6'd13; elo0 = 64'hDEAD; elo1 = 64'hBEEF;
      end else begin
         ehi_vppn = 35'(vppn); idx_ps = 6'(ps); elo0 = lo0; elo1 = lo0 + 64'h1000;
         rf_vppn = 35'(vppn ^ 35'h333); rf_ps = 6'd13; rf_lo0 = 64'hF00D; rf_lo1 = 64'hCAFE;
      end
      fill_req = 1;
      cycle();
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int nway, nfa;
      ps_support = (64'd1 << 12) | (64'd1 << 14) | (64'd1 << 21);
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(wr_en == 0 && old_inval == 0 && wr_index == 0 && wr_ps_en == 0, "R9",
          "reset outputs", {wr_en, old_inval, wr_ps_en}, 0);
      rst_n = 1;
      @(negedge clk);
      cycle(); // idle cycle, R8
      // set-assoc fills, normal and refill mode, varied lines
      for (int i = 0; i < 12; i++) fill(i[0], 64'h1234500 + i * 37, 12, 64'h100 * i, 5);
      // repeated fills to one line: ways collide, tags and global bit vary (R7, R4)
      for (int i = 0; i < 48; i++)
         fill(i % 3 == 0, 64'h7700 + (i * 256), 12, (i % 5 == 0) ? 64'h40 : 64'h0, i % 3);
      // R3 with a larger shared size
      shared_ps = 6'd14;
      for (int i = 0; i < 10; i++) fill(i[0], 64'h3_0000 + i * 4 + i * 1024, 14, 64'h80, 7);
      // associative region fills
      for (int i = 0; i < 30; i++) fill(i[0], 64'h900 + i, (i % 2) ? 21 : 12, i[1] ? 64'h40 : 0, i % 2);
      // R1: illegal requested size, then illegal shared size
      fill(0, 64'h55, 13, 0, 1);
      fill(1, 64'h55, 13, 0, 1);
      shared_ps = 6'd13;
      fill(0, 64'h55, 12, 0, 1);
      shared_ps = 6'd12;
      // R8: idle after activity, back-to-back fill then idle
      fill(0, 64'h77, 12, 0, 2);
      cycle();
      // R1 no state change: same slot line reused after illegal attempt still judged by model
      for (int i = 0; i < 8; i++) fill(0, 64'h7700, 12, 0, 9);
      nway = 0; nfa = 0;
      foreach (way_seen[i]) nway += way_seen[i];
      foreach (fa_seen[i]) nfa += fa_seen[i];
      chk(nway > 1, "R4", "distinct ways", nway, 2);
      chk(nfa > 1, "R10", "distinct assoc slots", nfa, 2);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule